// File: doc/BRIEF.md
# HDLC Receive Frame Status Checker

This block watches a received HDLC frame from its opening strobe to its closing strobe or abort, and builds a compact per-frame status word. It counts the bytes of the frame against a programmable maximum length and checks the final CRC remainder against the good-frame residue. It also collects the overrun and carrier-loss events seen during the frame, and takes the alignment and buffer flags that arrive with the closing strobe. When the frame closes, the status word and the byte count are presented with a one-cycle done strobe. They then hold until the next frame opens.

Five 16-bit statistics counters run alongside the frame tracking. They count CRC failures, aborted frames, frames discarded for lack of a receive buffer, retransmissions after a collision, and over-length frames. Each counter wraps modulo 2^16, and a synchronous clear input zeroes all five.

The control is a three-state machine. `ST_IDLE` waits for a frame. An accepted start strobe moves it to `ST_RECV`, where bytes and events are gathered. `eof` or `abort_det` moves it from `ST_RECV` to `ST_DONE`, which lasts one cycle. From `ST_DONE` it returns to `ST_IDLE`, or moves straight to `ST_RECV` if a start strobe arrives in that cycle.

Top module: `hdlc_rx_status`

## Requirements
- R1: After reset, `frame_done` is 0, `frame_stat` and `frame_len` are 0, and all five counters read 0.
- R2: The byte count advances on `byte_vld` only in `ST_RECV`, including the closing cycle. The reported `frame_len` is min(bytes, `max_len`), so the count saturates at the limit.
- R3: `frame_stat` bit 5 (length violation) is 1 exactly when the frame held more than `max_len` bytes. Each such non-aborted frame adds one to `cnt_lenviol`.
- R4: `frame_stat` bit 2 (CRC error) is 1 when `crc_rem` at `eof` differs from the good residue. That residue is 0xF0B8 when `CRC_W`=16 and 0xDEBB20E3 when `CRC_W`=32. Each such frame adds one to `cnt_crc`.
- R5: `abort_det` in `ST_RECV` ends the frame with `frame_stat` = 6'b001000 (bit 3 only) and adds one to `cnt_abort`. The CRC, length and discard counters are left unchanged; `abort_det` takes priority over `eof`.
- R6: `frame_stat` bit 1 is set if `overrun` pulsed during the frame, and bit 0 if `cd_lost` pulsed during it. Bit 4 is `misalign` sampled with `eof`.
- R7: `no_buf` high with a non-aborted `eof` adds one to `cnt_discard`.
- R8: Every cycle with `retx_coll` high adds one to `cnt_retx`, in any state.
- R9: `frame_done` is high for exactly the one cycle after the closing edge. Status and length hold afterwards, and both read 0 from the edge that accepts the next `sof`.
- R10: `sof` in `ST_RECV` is ignored; the byte count of the frame in progress continues.
- R11: The counters wrap from 0xFFFF to 0. `clr_stats` zeroes all counters at the next edge and takes priority over any increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_stats | input | 1 | Synchronous clear of all counters |
| max_len | input | LEN_W | Maximum frame length in bytes |
| sof | input | 1 | Start-of-frame strobe |
| byte_vld | input | 1 | One received byte this cycle |
| eof | input | 1 | Closing-flag strobe |
| crc_rem | input | CRC_W | CRC remainder, valid with eof |
| misalign | input | 1 | Frame not a whole number of octets, valid with eof |
| no_buf | input | 1 | No receive buffer was available, valid with eof |
| abort_det | input | 1 | Abort sequence strobe |
| overrun | input | 1 | Receiver overrun strobe |
| cd_lost | input | 1 | Carrier-lost strobe |
| retx_coll | input | 1 | Transmit-side collision retransmit strobe |
| frame_done | output | 1 | One-cycle frame-complete strobe |
| frame_stat | output | 6 | {lenviol, misalign, abort, crcerr, overrun, cdlost} |
| frame_len | output | LEN_W | Saturated byte count |
| cnt_crc | output | CNT_W | CRC error counter |
| cnt_abort | output | CNT_W | Abort counter |
| cnt_discard | output | CNT_W | Discarded-frame counter |
| cnt_retx | output | CNT_W | Retransmission counter |
| cnt_lenviol | output | CNT_W | Over-length frame counter |

## Verification
A state machine stuck in `ST_RECV` or `ST_DONE` shows up at the first frame close: either the done strobe is missing or it lasts two cycles. A missed clear at start of frame leaves stale status bits in the next status word. A length counter that wraps instead of saturating reports a short length with bit 5 clear as soon as a frame exceeds the limit. Counter faults show up one frame after the event that should have counted, and the wrap point is reached by a full 65536-pulse sweep.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic lg;
        logic no;
        logic ab;
        logic cr;
        logic ov;
        logic cd;
    } frame_stat_t;

    localparam int unsigned NUM_CNT  = 5;
    localparam int unsigned CNT_CRC  = 0;
    localparam int unsigned CNT_ABT  = 1;
    localparam int unsigned CNT_DISC = 2;
    localparam int unsigned CNT_RETX = 3;
    localparam int unsigned CNT_LEN  = 4;

    function automatic logic [31:0] good_residue(input int unsigned w);
        return (w == 32) ? 32'hDEBB_20E3 : 32'h0000_F0B8;
    endfunction

endpackage

// File: rtl/hdlc_len_tracker.sv
module hdlc_len_tracker #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [LEN_W-1:0] lim_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic             over_o,
    output logic             over_nxt_o
);
    logic [LEN_W-1:0] cnt_q;
    logic             over_q;
    logic             at_lim;

    assign at_lim = (cnt_q == lim_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            over_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            over_q <= 1'b0;
        end else if (inc_i) begin
            if (at_lim) over_q <= 1'b1;
            else        cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cnt_o      = cnt_q;
    assign over_o     = over_q;
    assign over_nxt_o = over_q | (inc_i & at_lim);

    // R2: a byte arriving at the limit marks the frame as over-length
    assert_len_saturate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && at_lim) |=> over_q)
        else $error("length tracker missed saturation");

    // R2: once over-length, the count never moves until the next clear
    assert_len_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (over_q && !clr_i && $stable(lim_i)) |=> $stable(cnt_q))
        else $error("length count moved after saturation");

endmodule

// File: rtl/hdlc_stat_counter.sv
module hdlc_stat_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R11: clear wins over any increment
    assert_clr_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0))
        else $error("counter not zero after clear");

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status #(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_stats,
    input  logic [LEN_W-1:0] max_len,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic             eof,
    input  logic [CRC_W-1:0] crc_rem,
    input  logic             misalign,
    input  logic             no_buf,
    input  logic             abort_det,
    input  logic             overrun,
    input  logic             cd_lost,
    input  logic             retx_coll,
    output logic             frame_done,
    output logic [5:0]       frame_stat,
    output logic [LEN_W-1:0] frame_len,
    output logic [CNT_W-1:0] cnt_crc,
    output logic [CNT_W-1:0] cnt_abort,
    output logic [CNT_W-1:0] cnt_discard,
    output logic [CNT_W-1:0] cnt_retx,
    output logic [CNT_W-1:0] cnt_lenviol
);
    import hdlc_rx_pkg::*;

    localparam logic [CRC_W-1:0] GOOD_RES = CRC_W'(good_residue(CRC_W));

    rx_state_e   state_q, state_d;
    frame_stat_t stat_q, stat_d;
    logic        ov_acc_q, cd_acc_q;
    logic        in_recv, sof_take, end_evt, aborted, crc_good;
    logic        over_nxt, over_now;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

    assign in_recv  = (state_q == ST_RECV);
    assign sof_take = sof && !in_recv;
    assign aborted  = in_recv && abort_det;
    assign end_evt  = in_recv && (abort_det || eof);
    assign crc_good = (crc_rem == GOOD_RES);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sof) state_d = ST_RECV;
            ST_RECV: if (abort_det || eof) state_d = ST_DONE;
            ST_DONE: state_d = sof ? ST_RECV : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    hdlc_len_tracker #(.LEN_W(LEN_W)) u_len (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .clr_i      (sof_take),
        .inc_i      (in_recv && byte_vld),
        .lim_i      (max_len),
        .cnt_o      (frame_len),
        .over_o     (over_now),
        .over_nxt_o (over_nxt)
    );

    // status word at frame close
    always_comb begin
        stat_d = '0;
        if (aborted) begin
            stat_d.ab = 1'b1;
        end else begin
            stat_d.lg = over_nxt;
            stat_d.no = misalign;
            stat_d.cr = !crc_good;
            stat_d.ov = ov_acc_q | overrun;
            stat_d.cd = cd_acc_q | cd_lost;
        end
    end

    // output / status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            ov_acc_q <= 1'b0;
            cd_acc_q <= 1'b0;
        end else if (sof_take) begin
            stat_q   <= '0;
            ov_acc_q <= 1'b0;
            cd_acc_q <= 1'b0;
        end else if (in_recv) begin
            if (overrun) ov_acc_q <= 1'b1;
            if (cd_lost) cd_acc_q <= 1'b1;
            if (end_evt) stat_q   <= stat_d;
        end
    end

    assign frame_done = (state_q == ST_DONE);
    assign frame_stat = stat_q;

    always_comb begin
        cnt_inc           = '0;
        cnt_inc[CNT_CRC]  = end_evt && !aborted && !crc_good;
        cnt_inc[CNT_ABT]  = aborted;
        cnt_inc[CNT_DISC] = end_evt && !aborted && no_buf;
        cnt_inc[CNT_RETX] = retx_coll;
        cnt_inc[CNT_LEN]  = end_evt && !aborted && over_nxt;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        hdlc_stat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_i  (clk),
            .rst_ni (rst_n),
            .clr_i  (clr_stats),
            .inc_i  (cnt_inc[g]),
            .cnt_o  (cnt_arr[g])
        );
    end

    assign cnt_crc     = cnt_arr[CNT_CRC];
    assign cnt_abort   = cnt_arr[CNT_ABT];
    assign cnt_discard = cnt_arr[CNT_DISC];
    assign cnt_retx    = cnt_arr[CNT_RETX];
    assign cnt_lenviol = cnt_arr[CNT_LEN];

    // R9: done lasts a single cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done)
        else $error("done strobe longer than one cycle");

    // R5: aborted frame shows only the abort bit
    assert_abort_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_stat[3]) |-> (frame_stat == 6'b001000))
        else $error("aborted frame carries extra status");

    // R9: status and length are clear while a new frame is gathered
    assert_clear_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && $past(state_q) != ST_RECV) |-> (frame_stat == 6'd0 && frame_len == '0))
        else $error("stale status at frame start");

    // R3: a closed frame above the limit reports the violation bit
    assert_lenviol_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_stat[3] && over_now) |-> frame_stat[5])
        else $error("length violation not reported");

endmodule

// File: tb/hdlc_rx_status_bench.sv
module hdlc_rx_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_stats = 1'b0;
    logic [15:0] max_len = 16'd5;
    logic        sof = 1'b0, byte_vld = 1'b0, eof = 1'b0;
    logic [15:0] crc_rem = 16'hF0B8;
    logic        misalign = 1'b0, no_buf = 1'b0, abort_det = 1'b0;
    logic        overrun = 1'b0, cd_lost = 1'b0, retx_coll = 1'b0;
    logic        frame_done;
    logic [5:0]  frame_stat;
    logic [15:0] frame_len, cnt_crc, cnt_abort, cnt_discard, cnt_retx, cnt_lenviol;

    int errors = 0;
    int checks = 0;
    int e_crc = 0, e_abt = 0, e_disc = 0, e_retx = 0, e_len = 0;

    always #4 clk = ~clk;

    hdlc_rx_status u_hdlc_rx_status (
        .clk(clk), .rst_n(rst_n), .clr_stats(clr_stats), .max_len(max_len),
        .sof(sof), .byte_vld(byte_vld), .eof(eof), .crc_rem(crc_rem),
        .misalign(misalign), .no_buf(no_buf), .abort_det(abort_det),
        .overrun(overrun), .cd_lost(cd_lost), .retx_coll(retx_coll),
        .frame_done(frame_done), .frame_stat(frame_stat), .frame_len(frame_len),
        .cnt_crc(cnt_crc), .cnt_abort(cnt_abort), .cnt_discard(cnt_discard),
        .cnt_retx(cnt_retx), .cnt_lenviol(cnt_lenviol)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk_counters(input string tag);
        chk({tag, " R4 cnt_crc"},     cnt_crc,     e_crc[15:0]);
        chk({tag, " R5 cnt_abort"},   cnt_abort,   e_abt[15:0]);
        chk({tag, " R7 cnt_discard"}, cnt_discard, e_disc[15:0]);
        chk({tag, " R8 cnt_retx"},    cnt_retx,    e_retx[15:0]);
        chk({tag, " R3 cnt_lenviol"}, cnt_lenviol, e_len[15:0]);
    endtask

    // one frame: n bytes, optional mid-frame sof, events, then eof or abort
    task automatic run_frame(input string tag, input int n, input logic [15:0] res,
                             input logic mis, input logic nob, input logic ovr,
                             input logic cdl, input logic abt, input logic mid_sof,
                             input logic last_byte_at_end);
        int body = last_byte_at_end && n > 0 ? n - 1 : n;
        int lim  = int'(max_len);
        int exp_len = n < lim ? n : lim;
        logic lg = (n > lim);
        logic [5:0] exp_stat;
        sof = 1'b1; cyc(); sof = 1'b0;
        chk({tag, " R9 stat clear at start"}, {26'd0, frame_stat}, 32'd0);
        chk({tag, " R9 len clear at start"}, frame_len, 32'd0);
        for (int i = 0; i < body; i++) begin
            byte_vld = 1'b1;
            sof = mid_sof && (i == 0);
            cyc();
        end
        byte_vld = 1'b0; sof = 1'b0;
        if (ovr) begin overrun = 1'b1; cyc(); overrun = 1'b0; end
        if (cdl) begin cd_lost = 1'b1; cyc(); cd_lost = 1'b0; end
        byte_vld = last_byte_at_end && n > 0;
        crc_rem = res; misalign = mis; no_buf = nob;
        if (abt) abort_det = 1'b1; else eof = 1'b1;
        cyc();
        byte_vld = 1'b0; eof = 1'b0; abort_det = 1'b0;
        misalign = 1'b0; no_buf = 1'b0; crc_rem = 16'hF0B8;
        if (abt) begin
            exp_stat = 6'b001000;
            e_abt++;
        end else begin
            exp_stat = {lg, mis, 1'b0, res != 16'hF0B8, ovr, cdl};
            if (res != 16'hF0B8) e_crc++;
            if (nob) e_disc++;
            if (lg) e_len++;
        end
        chk({tag, " R9 done high"}, {31'd0, frame_done}, 32'd1);
        chk({tag, " R2 frame_len"}, frame_len, exp_len);
        chk({tag, " R3/R6 frame_stat"}, {26'd0, frame_stat}, {26'd0, exp_stat});
        chk_counters(tag);
        cyc();
        chk({tag, " R9 done low"}, {31'd0, frame_done}, 32'd0);
        chk({tag, " R9 stat held"}, {26'd0, frame_stat}, {26'd0, exp_stat});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 done", {31'd0, frame_done}, 32'd0);
        chk("R1 stat", {26'd0, frame_stat}, 32'd0);
        chk("R1 len", frame_len, 32'd0);
        chk_counters("R1");

        // R2 R3 sweep of limits and lengths
        for (int m = 0; m <= 4; m++) begin
            max_len = 16'(m);
            for (int n = 0; n <= 7; n++)
                run_frame("R2 sweep", n, 16'hF0B8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, n[0]);
        end
        max_len = 16'd5;

        // R4 CRC residue
        run_frame("R4 bad crc", 3, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R4 good crc", 3, 16'hF0B8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6 events and alignment
        run_frame("R6 ov", 2, 16'hF0B8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R6 cd mis", 4, 16'hF0B8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R7 discard
        run_frame("R7 nobuf", 2, 16'hF0B8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 abort with every other fault present
        run_frame("R5 abort", 8, 16'h0BAD, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        // R10 mid-frame sof ignored
        run_frame("R10 mid sof", 4, 16'hF0B8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // R5 abort beats eof in the same cycle
        sof = 1'b1; cyc(); sof = 1'b0;
        eof = 1'b1; abort_det = 1'b1; crc_rem = 16'h0; cyc();
        eof = 1'b0; abort_det = 1'b0; crc_rem = 16'hF0B8;
        e_abt++;
        chk("R5 abort over eof stat", {26'd0, frame_stat}, 32'h8);
        chk_counters("R5 abort over eof");
        cyc();

        // R8 retx in idle and across a frame
        retx_coll = 1'b1; repeat (3) cyc(); retx_coll = 1'b0;
        e_retx += 3;
        chk("R8 retx idle", cnt_retx, e_retx[15:0]);

        // R11 clear priority
        clr_stats = 1'b1; retx_coll = 1'b1; cyc(); clr_stats = 1'b0; retx_coll = 1'b0;
        e_crc = 0; e_abt = 0; e_disc = 0; e_retx = 0; e_len = 0;
        chk_counters("R11 clear");

        // R11 wrap
        retx_coll = 1'b1; repeat (65535) cyc(); retx_coll = 1'b0;
        chk("R11 retx at max", cnt_retx, 32'hFFFF);
        retx_coll = 1'b1; cyc(); retx_coll = 1'b0;
        chk("R11 retx wrapped", cnt_retx, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule